// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a data cache for a 24-bit physical address space. Words are 32 bits wide and each line holds several words. The requester presents a read or a write with per-byte enables. The address picks one set, and the tag is compared against every way of that set at once. A hit finishes in the cycle it is presented: read data comes back and write data is merged into the line, with no stall.

On a miss the block raises a stall and picks a victim in the selected set.
- An invalid way is taken first. Otherwise the least recently used way is taken.
- If the victim holds modified data, it is first written out as a burst write.
- A burst read then fills the line from memory, and the access repeats as a hit.
- A write that misses allocates the line, then merges its enabled bytes into the freshly loaded word.

Memory is updated only when a modified line is evicted. The memory side uses a request/ready handshake, with one word moved per ready cycle at consecutive word addresses. The number of ways (2^WAY_LOG2), the total line count (2^LINE_LOG2) and the words per line (2^WORD_LOG2) are parameters. Adding ways shrinks the set count and leaves the capacity unchanged. WAY_LOG2 must be at least 1 and smaller than LINE_LOG2.

Top module: `wbc_cache`

## Requirements
- R1: While reset is held and right after it, req_stall, req_ack and mem_req are low. Every line is invalid after reset, so the first access to any address misses.
- R2: An access to a resident line gives req_ack high and req_stall low in the same cycle it is presented, and starts no memory transfer.
- R3: A read returns the latest value written to that word. On a write, req_be bit b enables byte b, which is data bits [8b+7:8b]; disabled bytes keep their old value.
- R4: With the defaults, the address splits as byte [1:0], word in line [3:2], set [6:4] and tag [23:7]. Each set holds two lines independently, and accesses to one set never displace lines of another set.
- R5: On a miss, the victim is the lowest-numbered invalid way of the set if one exists. Otherwise it is the way of that set least recently used by a completed access.
- R6: A write hit changes no memory word. Evicting a line written since its fill performs one burst write of its four words with the cache's data. Evicting a line not written since its fill performs no memory write.
- R7: Each burst holds mem_req high. It starts at a line-aligned address and steps mem_addr by 4 after each cycle with mem_ready high. While mem_ready is low, mem_req and mem_addr stay unchanged. A fill moves exactly four words.
- R8: A missing access keeps req_stall high and req_ack low until its line is loaded. It then acks in the cycle after the last fill word is accepted.
- R9: A write miss fills the line, then merges its enabled bytes into it. The line is then treated as written, and a later eviction writes the merged data back.
- R10: When a miss needs a writeback, the burst write comes before the burst read, with mem_req low for at least one cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until acked |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Physical byte address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_stall | output | 1 | Requester must hold the access |
| req_ack | output | 1 | Access completes at this clock edge |
| req_rdata | output | 32 | Read data, valid with req_ack |
| mem_req | output | 1 | Burst in progress |
| mem_we | output | 1 | Burst direction, 1 is write |
| mem_addr | output | 24 | Byte address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_ready | input | 1 | Memory accepts or supplies the beat |
| mem_rdata | input | 32 | Read data of the current beat |

## Verification
Each fault in the internal state shows up at the ports within a few accesses:
- A corrupted tag or valid bit turns an expected hit into a stall, or an expected miss into an immediate ack, in the very cycle the access is presented.
- A wrong age order picks the wrong victim. This is seen one access later, when a line that should have survived stalls again.
- A lost or spurious dirty bit shows as a missing or extra burst write at the eviction.
- Stale line data appears either in the read data or in the words written back, both checked against an independent model of memory contents.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int PA_W      = 24;
  localparam int WORD_W    = 32;
  localparam int BE_W      = WORD_W / 8;
  localparam int BYTE_LOG2 = 2;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_WBACK,
    CS_TURN,
    CS_FILL
  } cache_state_e;

  // replace the enabled bytes of a stored word with the new ones
  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 17,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]       set_valid,
  input  logic [TAG_W-1:0]      look_tag,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign hit_vec[g] = set_valid[g] && (set_tags[g*TAG_W +: TAG_W] == look_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
  parameter int WAYS = 2,
  parameter int SETS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  input  logic [WAYS-1:0]  query_valid,
  output logic [WAY_W-1:0] victim_way
);
  // per way an age: 0 is most recent, WAYS-1 is oldest; ages in a set form a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_q[touch_set][w] <= '0;
        end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !query_valid[w]) begin
        victim_way = WAY_W'(w);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[query_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/wbc_burst.sv
module wbc_burst #(
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              mem_ready,
  output logic [BEAT_W-1:0] beat,
  output logic              last
);
  logic [BEAT_W-1:0] beat_q;

  assign beat = beat_q;
  assign last = active && mem_ready && (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (!active || last) begin
      beat_q <= '0;
    end else if (mem_ready) begin
      beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int WAY_LOG2  = 1,
  parameter int LINE_LOG2 = 4,
  parameter int WORD_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_stall,
  output logic              req_ack,
  output logic [WORD_W-1:0] req_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int WAYS     = 1 << WAY_LOG2;
  localparam int SET_LOG2 = LINE_LOG2 - WAY_LOG2;
  localparam int SETS     = 1 << SET_LOG2;
  localparam int WPL      = 1 << WORD_LOG2;
  localparam int LINES    = 1 << LINE_LOG2;
  localparam int IDX_LO   = BYTE_LOG2 + WORD_LOG2;
  localparam int TAG_LO   = IDX_LO + SET_LOG2;
  localparam int TAG_W    = PA_W - TAG_LO;
  localparam int SLOT_W   = LINE_LOG2 + WORD_LOG2;
  localparam int SLOTS    = 1 << SLOT_W;

  // ---------------- address arithmetic ----------------
  function automatic logic [TAG_W-1:0] tag_of(input logic [PA_W-1:0] a);
    return a[PA_W-1:TAG_LO];
  endfunction

  function automatic logic [SET_LOG2-1:0] set_of(input logic [PA_W-1:0] a);
    return a[TAG_LO-1:IDX_LO];
  endfunction

  function automatic logic [WORD_LOG2-1:0] word_of(input logic [PA_W-1:0] a);
    return a[IDX_LO-1:BYTE_LOG2];
  endfunction

  function automatic logic [LINE_LOG2-1:0] line_of(input logic [WAY_LOG2-1:0] way,
                                                   input logic [SET_LOG2-1:0] set);
    return {way, set};
  endfunction

  function automatic logic [PA_W-1:0] beat_addr(input logic [TAG_W-1:0] tag,
                                                input logic [SET_LOG2-1:0] set,
                                                input logic [WORD_LOG2-1:0] word);
    return {tag, set, word, {BYTE_LOG2{1'b0}}};
  endfunction

  // ---------------- storage ----------------
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [WORD_W-1:0] data_q [SLOTS];

  cache_state_e state_q, state_d;

  logic [WAY_LOG2-1:0]  vic_way_q;
  logic [SET_LOG2-1:0]  miss_set_q;
  logic [TAG_W-1:0]     miss_tag_q;
  logic [TAG_W-1:0]     vic_tag_q;

  // ---------------- lookup ----------------
  logic [TAG_W-1:0]      req_tag;
  logic [SET_LOG2-1:0]   req_set;
  logic [WORD_LOG2-1:0]  req_word;
  logic                  unused_byte_bits;

  assign req_tag          = tag_of(req_addr);
  assign req_set          = set_of(req_addr);
  assign req_word         = word_of(req_addr);
  assign unused_byte_bits = ^req_addr[BYTE_LOG2-1:0];

  logic [WAYS*TAG_W-1:0] set_tags;
  logic [WAYS-1:0]       set_valid;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w*TAG_W +: TAG_W] = tag_q[line_of(WAY_LOG2'(w), req_set)];
      set_valid[w]               = valid_q[line_of(WAY_LOG2'(w), req_set)];
    end
  end

  logic [WAYS-1:0]     hit_vec;
  logic                hit;
  logic [WAY_LOG2-1:0] hit_way;
  logic [WAY_LOG2-1:0] victim_way;

  wbc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .set_tags  (set_tags),
    .set_valid (set_valid),
    .look_tag  (req_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  // ---------------- named internal events ----------------
  logic hit_ack;
  logic miss_go;
  logic active;
  logic wb_done;
  logic fill_done;
  logic fill_beat;
  logic last;
  logic [WORD_LOG2-1:0] beat;

  assign hit_ack   = req_valid && (state_q == CS_IDLE) && hit;
  assign miss_go   = req_valid && (state_q == CS_IDLE) && !hit;
  assign active    = (state_q == CS_WBACK) || (state_q == CS_FILL);
  assign wb_done   = (state_q == CS_WBACK) && last;
  assign fill_done = (state_q == CS_FILL) && last;
  assign fill_beat = (state_q == CS_FILL) && mem_ready;

  wbc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch       (hit_ack),
    .touch_set   (req_set),
    .touch_way   (hit_way),
    .query_set   (req_set),
    .query_valid (set_valid),
    .victim_way  (victim_way)
  );

  wbc_burst #(.BEATS(WPL)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .mem_ready (mem_ready),
    .beat      (beat),
    .last      (last)
  );

  logic [LINE_LOG2-1:0] hit_line;
  logic [LINE_LOG2-1:0] vic_line;
  logic [LINE_LOG2-1:0] buf_line;
  logic                 vic_dirty;

  assign hit_line  = line_of(hit_way, req_set);
  assign vic_line  = line_of(victim_way, req_set);
  assign buf_line  = line_of(vic_way_q, miss_set_q);
  assign vic_dirty = valid_q[vic_line] && dirty_q[vic_line];

  // ---------------- requester side ----------------
  assign req_ack   = hit_ack;
  assign req_stall = req_valid && !hit_ack;
  assign req_rdata = data_q[{hit_line, req_word}];

  // ---------------- memory side ----------------
  assign mem_req   = active;
  assign mem_we    = (state_q == CS_WBACK);
  assign mem_addr  = beat_addr(mem_we ? vic_tag_q : miss_tag_q, miss_set_q, beat);
  assign mem_wdata = data_q[{buf_line, beat}];

  // ---------------- control ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CS_IDLE:  if (miss_go) state_d = vic_dirty ? CS_WBACK : CS_FILL;
      CS_WBACK: if (last) state_d = CS_TURN;
      CS_TURN:  state_d = CS_FILL;
      CS_FILL:  if (last) state_d = CS_IDLE;
      default:  state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      vic_way_q  <= '0;
      miss_set_q <= '0;
      miss_tag_q <= '0;
      vic_tag_q  <= '0;
    end else begin
      state_q <= state_d;
      if (miss_go) begin
        vic_way_q  <= victim_way;
        miss_set_q <= req_set;
        miss_tag_q <= req_tag;
        vic_tag_q  <= tag_q[vic_line];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done) begin
      valid_q[buf_line] <= 1'b1;
      dirty_q[buf_line] <= 1'b0;
    end else if (hit_ack && req_write) begin
      dirty_q[hit_line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[buf_line] <= miss_tag_q;
  end

  always_ff @(posedge clk) begin
    if (fill_beat) begin
      data_q[{buf_line, beat}] <= mem_rdata;
    end else if (hit_ack && req_write) begin
      data_q[{hit_line, req_word}] <= merge_bytes(data_q[{hit_line, req_word}], req_wdata, req_be);
    end
  end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
  parameter int NWAYS = 2,
  parameter int PA_W  = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_stall,
  input logic            req_ack,
  input logic            mem_req,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_addr,
  input logic [NWAYS-1:0] hit_vec,
  input logic            fill_done,
  input logic            wb_done
);
  // R4
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !fill_done && !wb_done) |=> (mem_addr == $past(mem_addr) + PA_W'(4)));

  // R7
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R8
  retry_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && req_valid) |=> req_ack);

  // R8
  stall_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_valid) |-> req_stall);

  // R10
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> !mem_req);

  // R2
  quiet_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !mem_req);
endmodule

bind wbc_cache wbc_cache_chk #(.NWAYS(1 << WAY_LOG2), .PA_W(24)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_stall (req_stall),
  .req_ack   (req_ack),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .hit_vec   (hit_vec),
  .fill_done (fill_done),
  .wb_done   (wb_done)
);

// File: tb/wbc_cache_test.sv
module wbc_cache_test;
  import wbc_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_write;
  logic [23:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        req_stall, req_ack;
  logic [31:0] req_rdata;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;

  wbc_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .req_stall(req_stall), .req_ack(req_ack), .req_rdata(req_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // memory model contents and the architectural view of memory
  logic [31:0] mem  [1024];
  logic [31:0] arch [1024];

  // reference cache: 8 sets, 2 ways; lru_way = way to evict next
  logic [16:0] rt [8][2];
  bit          rv [8][2];
  bit          rdy[8][2];
  bit          lru_way [8];

  int total = 0, bad = 0;
  int ncyc = 0, wr_beats = 0, rd_beats = 0, seq_err = 0, last_fill_n = -10;
  int beat_cnt = 0;
  bit first_pending = 0, first_we = 0, prev_req = 0, burst_we = 0, finished = 0;
  logic [23:0] burst_base = '0;
  logic [31:0] expq [$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [23:0] A(input int t, input int s, input int w);
    return 24'((t << 7) | (s << 4) | (w << 2));
  endfunction

  // memory side: decide and commit at the falling edge
  always @(negedge clk) begin
    ncyc++;
    if (mem_req && !prev_req) begin
      beat_cnt   = 0;
      burst_base = mem_addr;
      burst_we   = mem_we;
      if (burst_base[3:0] != 4'h0) seq_err++;
      if (first_pending) begin
        first_we      = mem_we;
        first_pending = 0;
      end
    end
    prev_req  = mem_req;
    mem_ready = mem_req && (ncyc % 3 != 0);
    if (mem_ready) begin
      if (mem_addr != burst_base + 24'(4 * beat_cnt) || mem_we != burst_we) seq_err++;
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        wr_beats++;
      end else begin
        mem_rdata = mem[mem_addr[11:2]];
        rd_beats++;
        if (beat_cnt == 3) last_fill_n = ncyc;
      end
      beat_cnt++;
    end
  end

  // scoreboard monitor: each completed read is compared with the queued value
  always @(negedge clk) begin
    #2;
    if (rst_n && req_valid && req_ack && !req_write) begin
      if (expq.size() == 0) chk(0, "R3 (no expected read queued)", req_rdata, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(req_rdata == e, "R3 read data", req_rdata, e);
      end
    end
  end

  task automatic access(input bit wr, input logic [23:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input string rq);
    int s, idx, way, an, wr0, rd0;
    bit h, ewb;
    logic [16:0] tg, otag;
    logic [31:0] mb;
    s = int'(a[6:4]); tg = a[23:7]; idx = int'(a[11:2]);
    h = 0; ewb = 0; way = 0; otag = '0;
    for (int w = 0; w < 2; w++) if (rv[s][w] && rt[s][w] == tg) begin h = 1; way = w; end
    if (!h) begin
      way  = !rv[s][0] ? 0 : (!rv[s][1] ? 1 : int'(lru_way[s]));
      ewb  = rv[s][way] && rdy[s][way];
      otag = rt[s][way];
      rt[s][way] = tg; rv[s][way] = 1; rdy[s][way] = 0;
    end
    lru_way[s] = (way == 0);
    if (wr) begin
      rdy[s][way] = 1;
      arch[idx] = merge_bytes(arch[idx], wd, be);
    end else expq.push_back(arch[idx]);
    mb = mem[idx]; wr0 = wr_beats; rd0 = rd_beats;
    first_pending = !h;

    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    #1;
    chk(req_ack == h, {rq, " hit/miss at presentation"}, 32'(req_ack), 32'(h));
    if (!h) chk(req_stall == 1, "R8 stall on miss", 32'(req_stall), 1);
    while (!req_ack) begin
      @(negedge clk);
      #1;
    end
    an = ncyc;
    @(negedge clk);
    req_valid = 0;
    #1;
    if (!h) begin
      chk(an == last_fill_n + 1, "R8 ack after last fill beat", 32'(an), 32'(last_fill_n + 1));
      chk(rd_beats - rd0 == 4, "R7 fill beat count", 32'(rd_beats - rd0), 4);
      chk(wr_beats - wr0 == (ewb ? 4 : 0), "R6 writeback beat count", 32'(wr_beats - wr0), ewb ? 4 : 0);
      chk(first_we == ewb, "R10 writeback before fill", 32'(first_we), 32'(ewb));
      if (ewb) begin
        for (int k = 0; k < 4; k++) begin
          int vi;
          vi = int'(otag[4:0]) * 32 + s * 4 + k;
          chk(mem[vi] == arch[vi], "R6 written-back data", mem[vi], arch[vi]);
        end
      end
    end else begin
      chk(rd_beats == rd0 && wr_beats == wr0, "R2 no memory traffic on hit",
          32'(rd_beats - rd0 + wr_beats - wr0), 0);
    end
    if (wr) chk(mem[idx] == mb, "R6 memory untouched by write", mem[idx], mb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    mem_ready = 0; mem_rdata = '0;
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 32'h1000_0000 + 32'(i) * 32'h0001_0203;
      arch[i] = mem[i];
    end
    for (int s = 0; s < 8; s++) begin
      lru_way[s] = 0;
      for (int w = 0; w < 2; w++) begin rv[s][w] = 0; rdy[s][w] = 0; rt[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!req_stall && !req_ack && !mem_req, "R1 outputs in reset", {29'd0, req_stall, req_ack, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!req_stall && !req_ack && !mem_req, "R1 outputs after reset", {29'd0, req_stall, req_ack, mem_req}, 0);

    access(0, A(1,0,0), 4'h0, 0, "R1");
    access(0, A(1,0,3), 4'h0, 0, "R2");
    access(1, A(1,0,1), 4'b0101, 32'hCAFE_BEEF, "R2");
    access(0, A(2,0,2), 4'h0, 0, "R5");
    access(0, A(1,0,1), 4'h0, 0, "R3");
    access(0, A(3,0,0), 4'h0, 0, "R5");
    access(0, A(1,0,2), 4'h0, 0, "R5");
    access(0, A(3,0,1), 4'h0, 0, "R4");
    access(0, A(4,0,0), 4'h0, 0, "R6");
    access(1, A(6,1,2), 4'b1100, 32'h1234_5678, "R9");
    access(0, A(6,1,2), 4'h0, 0, "R9");
    access(0, A(1,1,0), 4'h0, 0, "R4");
    access(0, A(4,0,0), 4'h0, 0, "R4");
    access(0, A(7,1,0), 4'h0, 0, "R9");

    x = 32'h2545_F491;
    for (int i = 0; i < 300; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      access(x[8] & x[9], A(int'(x[2:0]), int'(x[4:3]), int'(x[7:6])), x[13:10], x ^ 32'h5A5A_0F0F, "R4");
    end

    chk(seq_err == 0, "R7 burst address sequence", 32'(seq_err), 0);
    chk(expq.size() == 0, "R3 every read answered", 32'(expq.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule